// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for a single Ethernet transceiver's management registers, reached through a small register-mapped host port. It removes the need for a real serial management bus. The host first loads a write-data register. It then writes a command register that names a PHY address, a register number and an opcode, and sets an initiate flag. The block applies the access to a file of 32 sixteen-bit registers. The result of a read access is placed in a read-data register, where the host can fetch it.

Not every register is read from storage. Basic status, link-partner ability, the vendor speed register and the diagnostics register are computed on each read. They depend on the `link_up` input and on the advertisement register (register 4). The control register (register 0) never keeps bit 15, the self-clearing reset bit, after a write.

The host port has no back-pressure. Every write on `host_wr` is accepted in the cycle it is presented. `host_rdata` is a combinational view of the register chosen by `host_sel`.

Top module: `phy_mgmt_model`

## Requirements
- R1: `host_sel` picks the host register: 0 = command, 1 = write-data, 2 = read-data, 3 = none (reads 0, writes ignored). In the command word, bits 28:24 are the PHY address, bits 20:16 the register number, bits 15:14 the opcode and bit 11 the initiate flag.
- R2: A command write with initiate set and opcode 1 stores write-data bits 15:0 into the named register.
- R3: A command write with initiate set and opcode 2 loads the read value into the read-data register (bits 15:0, upper bits zero). The result is visible from the next cycle. Opcodes 0 and 3, and any command with initiate clear, perform no access and leave the read-data register unchanged.
- R4: Reading the command register returns the last written command word with bit 7 forced to 1.
- R5: A read addressed to a PHY address other than the parameter `PHY_ADDR` (default 7) returns 0xFFFF. A write to such an address changes no register.
- R6: After reset, registers 0, 2, 3 and 4 hold 0x3100, 0x0300, 0xE400 and 0x01E1. All other stored registers hold 0, and the host registers read 0 (the command register reads 0x80).
- R7: Register 1 reads 0x782E while `link_up` is 1, and 0 while it is 0.
- R8: Register 5 reads 0x4001 OR (register 4 AND 0x01E0).
- R9: Register 17 always reads 0x8000.
- R10: While `link_up` is 1, register 18 has bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[6] OR reg4[8], with all other bits zero. While `link_up` is 0, it reads 0.
- R11: Bit 15 of register 0 is clear after any write, including a write of 1 to that bit.
- R12: Registers other than 1, 5, 17 and 18 read back their stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state feeding the computed registers |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected host register (combinational) |

## Verification
The checker watches the cycle-level rules on every cycle. These are the ready bit on command readback and the 0xFFFF result for a foreign read. They also cover the unchanged register file after a foreign write, the absence of bit 15 in stored register 0, the fixed vendor register, the zero basic status while the link is down, and a read-data register that holds still unless a read command arrives. The bench scenarios cover what depends on history. These are the reset contents, stored values read back after writes, and the way register 5 and register 18 follow a rewritten advertisement register. They also cover the no-access opcodes, the initiate flag left clear, and the field positions of the command word.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;
  localparam int REG_W   = 16;
  localparam int NREG    = 32;
  localparam int RADDR_W = $clog2(NREG);
  localparam int HOST_W  = 32;

  // Command word field positions
  localparam int PHY_LSB  = 24;
  localparam int REG_LSB  = 16;
  localparam int OP_LSB   = 14;
  localparam int GO_BIT   = 11;
  localparam int READY_BIT = 7;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_IDLE3 = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    logic [RADDR_W-1:0] phy;
    logic [RADDR_W-1:0] regn;
    mgmt_op_e           op;
    logic               go;
  } mgmt_cmd_t;

  function automatic logic [REG_W-1:0] reset_value(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phymgmt_pkg::*;
(
  input  logic [HOST_W-1:0] word,
  output mgmt_cmd_t         cmd
);
  always_comb begin
    cmd.phy  = word[PHY_LSB +: RADDR_W];
    cmd.regn = word[REG_LSB +: RADDR_W];
    cmd.op   = mgmt_op_e'(word[OP_LSB +: 2]);
    cmd.go   = word[GO_BIT];
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phymgmt_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = REG_W,
  localparam int AW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] store_flat
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val <= W'(reset_value(i));
      end else if (we && waddr == AW'(i)) begin
        if (i == 0) val <= wdata & ~(W'(1) << (W-1));
        else        val <= wdata;
      end
    end
    assign store_flat[i*W +: W] = val;
  end
endmodule

// File: rtl/phy_read_synth.sv
module phy_read_synth
  import phymgmt_pkg::*;
(
  input  logic [NREG*REG_W-1:0] store_flat,
  input  logic [RADDR_W-1:0]    regn,
  input  logic                  link_up,
  output logic [REG_W-1:0]      value
);
  logic [REG_W-1:0] adv;
  assign adv = store_flat[4*REG_W +: REG_W];

  always_comb begin
    value = store_flat[regn*REG_W +: REG_W];
    case (regn)
      RADDR_W'(1):  value = link_up ? 16'h782E : '0;
      RADDR_W'(5):  value = 16'h4001 | (adv & 16'h01E0);
      RADDR_W'(17): value = 16'h8000;
      RADDR_W'(18): begin
        value = '0;
        if (link_up) begin
          value[10] = adv[7] | adv[8];
          value[11] = adv[6] | adv[8];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phymgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        host_wr,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  logic [HOST_W-1:0]     cmd_q, wd_q;
  logic [REG_W-1:0]      rd_q;
  logic [NREG*REG_W-1:0] store_flat;
  logic [REG_W-1:0]      synth_val;
  mgmt_cmd_t             cmd;
  logic                  issue, mine, do_wr, do_rd;

  phy_cmd_decode u_dec (.word(host_wdata), .cmd(cmd));

  assign issue = host_wr && host_sel_e'(host_sel) == SEL_CMD && cmd.go;
  assign mine  = cmd.phy == PHY_ADDR;
  assign do_wr = issue && cmd.op == OP_WRITE && mine;
  assign do_rd = issue && cmd.op == OP_READ;

  phy_regfile #(.N(NREG), .W(REG_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(do_wr), .waddr(cmd.regn),
    .wdata(wd_q[REG_W-1:0]), .store_flat(store_flat)
  );

  phy_read_synth u_rs (
    .store_flat(store_flat), .regn(cmd.regn), .link_up(link_up), .value(synth_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (host_wr && host_sel_e'(host_sel) == SEL_CMD)   cmd_q <= host_wdata;
      if (host_wr && host_sel_e'(host_sel) == SEL_WDATA) wd_q  <= host_wdata;
      if (do_rd) rd_q <= mine ? synth_val : '1;
    end
  end

  always_comb begin
    case (host_sel_e'(host_sel))
      SEL_CMD:   host_rdata = cmd_q | (HOST_W'(1) << READY_BIT);
      SEL_WDATA: host_rdata = wd_q;
      SEL_RDATA: host_rdata = HOST_W'(rd_q);
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_checks.sv
module phy_mgmt_checks
  import phymgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  link_up,
  input logic                  host_wr,
  input logic [1:0]            host_sel,
  input logic [31:0]           host_wdata,
  input logic [31:0]           host_rdata,
  input logic [REG_W-1:0]      rd_q,
  input logic [NREG*REG_W-1:0] store_flat
);
  logic cmd_go, foreign;
  logic [1:0] op;
  logic [4:0] rn;
  assign cmd_go  = host_wr && host_sel == 2'd0 && host_wdata[11];
  assign op      = host_wdata[15:14];
  assign rn      = host_wdata[20:16];
  assign foreign = host_wdata[28:24] != PHY_ADDR;

  a_r4_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd0 |-> host_rdata[7]);

  a_r5_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && op == 2'd2 && foreign |=> rd_q == 16'hFFFF);

  a_r5_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && op == 2'd1 && foreign |=> $stable(store_flat));

  a_r11_no_reset_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !store_flat[15]);

  a_r9_vendor_reg: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && op == 2'd2 && !foreign && rn == 5'd17 |=> rd_q == 16'h8000);

  a_r7_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && op == 2'd2 && !foreign && rn == 5'd1 && !link_up |=> rd_q == 16'h0);

  a_r3_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_go && op == 2'd2) |=> $stable(rd_q));
endmodule

bind phy_mgmt_model phy_mgmt_checks #(.PHY_ADDR(PHY_ADDR)) u_checks (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_wr(host_wr),
  .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .rd_q(rd_q), .store_flat(store_flat)
);

// File: tb/test_phy_mgmt_model.sv
module test_phy_mgmt_model;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        link_up = 1;
  logic        host_wr = 0;
  logic [1:0]  host_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] mdl [32];
  logic [31:0] exp_q [$];
  logic [31:0] last_rd = 0;

  always #5 clk = ~clk;

  phy_mgmt_model #(.PHY_ADDR(5'd7)) i_phy_mgmt_model (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [31:0] cmd_word(input logic [4:0] phy, input logic [4:0] rn,
                                           input logic [1:0] op, input logic go);
    return {3'b0, phy, 3'b0, rn, op, 2'b0, go, 11'b0};
  endfunction

  function automatic logic [15:0] expect_reg(input int rn);
    logic [15:0] v;
    case (rn)
      1:  v = link_up ? 16'h782E : 16'h0;
      5:  v = 16'h4001 | (mdl[4] & 16'h01E0);
      17: v = 16'h8000;
      18: v = link_up ? {4'b0, mdl[4][6] | mdl[4][8], mdl[4][7] | mdl[4][8], 10'b0} : 16'h0;
      default: v = mdl[rn];
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  // monitor side: pop the oldest expectation and compare with read-data
  task automatic monitor_pop(input string req);
    logic [31:0] got, exp;
    host_read(2'd2, got);
    exp = exp_q.pop_front();
    check(req, got, exp);
    last_rd = exp;
  endtask

  // driver side: issue a read command and queue its expected result
  task automatic phy_rd(input logic [4:0] phy, input int rn, input string req);
    host_write(2'd0, cmd_word(phy, 5'(rn), 2'd2, 1'b1));
    exp_q.push_back(phy == 5'd7 ? {16'h0, expect_reg(rn)} : 32'h0000FFFF);
    monitor_pop(req);
  endtask

  task automatic phy_wr(input logic [4:0] phy, input int rn, input logic [15:0] d);
    host_write(2'd1, {16'hA5A5, d});
    host_write(2'd0, cmd_word(phy, 5'(rn), 2'd1, 1'b1));
    if (phy == 5'd7) begin
      mdl[rn] = d;
      mdl[0][15] = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
    mdl[0] = 16'h3100; mdl[2] = 16'h0300; mdl[3] = 16'hE400; mdl[4] = 16'h01E1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R6 reset state of host registers
    host_read(2'd2, v); check("R6 rdata reset", v, 32'h0);
    host_read(2'd0, v); check("R4 R6 cmd reset", v, 32'h80);
    host_read(2'd3, v); check("R1 none select", v, 32'h0);

    // R6 stored reset values
    phy_rd(7, 0, "R6 reg0");
    phy_rd(7, 2, "R6 reg2");
    phy_rd(7, 3, "R6 reg3");
    phy_rd(7, 4, "R6 reg4");
    phy_rd(7, 9, "R6 reg9");

    // R7 basic status both link states
    phy_rd(7, 1, "R7 link up");
    link_up = 0;
    phy_rd(7, 1, "R7 link down");
    phy_rd(7, 18, "R10 link down");
    link_up = 1;

    // R8 R10 with default advertisement
    phy_rd(7, 5, "R8 default adv");
    phy_rd(7, 18, "R10 default adv");
    phy_rd(7, 17, "R9 vendor");

    // R10 R8 patterns of reg4
    phy_wr(7, 4, 16'h0080); phy_rd(7, 18, "R10 adv 0080"); phy_rd(7, 5, "R8 adv 0080");
    phy_wr(7, 4, 16'h0040); phy_rd(7, 18, "R10 adv 0040");
    phy_wr(7, 4, 16'h0100); phy_rd(7, 18, "R10 adv 0100");
    phy_wr(7, 4, 16'h0020); phy_rd(7, 18, "R10 adv 0020"); phy_rd(7, 5, "R8 adv 0020");

    // R2 R12 stored write and readback
    phy_wr(7, 9, 16'hBEEF); phy_rd(7, 9, "R2 R12 reg9");
    phy_wr(7, 31, 16'h1234); phy_rd(7, 31, "R12 reg31");
    // writes to computed registers do not show through
    phy_wr(7, 17, 16'h0001); phy_rd(7, 17, "R9 after write");

    // R11 self-clearing bit
    phy_wr(7, 0, 16'hFFFF); phy_rd(7, 0, "R11 reg0 bit15");

    // R5 foreign address
    phy_rd(3, 2, "R5 foreign read");
    phy_wr(3, 9, 16'h0000); phy_rd(7, 9, "R5 foreign write ignored");

    // R3 no-access opcodes and initiate clear
    host_write(2'd0, cmd_word(7, 2, 2'd0, 1'b1));
    host_read(2'd2, v); check("R3 opcode 0", v, last_rd);
    host_write(2'd0, cmd_word(7, 2, 2'd3, 1'b1));
    host_read(2'd2, v); check("R3 opcode 3", v, last_rd);
    host_write(2'd0, cmd_word(7, 2, 2'd2, 1'b0));
    host_read(2'd2, v); check("R3 initiate clear", v, last_rd);
    host_write(2'd1, 32'h0000_5555);
    host_write(2'd0, cmd_word(7, 12, 2'd1, 1'b0));
    phy_rd(7, 12, "R3 write without initiate");

    // R1 R4 command readback and field positions
    host_read(2'd0, v); check("R1 R4 cmd readback", v, cmd_word(7, 12, 2'd2, 1'b1) | 32'h80);
    host_read(2'd1, v); check("R1 wdata readback", v, 32'h0000_5555);
    host_write(2'd2, 32'hDEAD_0000);
    host_read(2'd2, v); check("R1 rdata not writable", v, last_rd);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule